// File: doc/BRIEF.md
# Ship-Mode Wake Sequencer

This controller decides when a battery-powered device leaves its lowest-power shipping state and when it goes back. It watches four digital flags: an active-low push button, an adapter-valid comparator, a comparator saying the battery is above the highest selectable undervoltage threshold, and a one-cycle ship-request strobe from the register file. Button hold time is measured in pulses of a tick-enable input and compared against a wake duration and a reset duration, both parameters.

A wake is a two-phase event. Pressing the button with no adapter and a healthy battery turns the pass path on at once. The wake only completes, and host serial access is only granted, once the button has stayed low for the wake duration. An adapter alone wakes the device fully. A ship request made while the adapter is present does not take effect at once. It is held pending until the adapter goes away. A button still held past the reset duration when an adapter arrives arms the same pending entry. That pending entry is cancelled if the button then stays low for longer than the wake duration.

Top module: `shipWakeSeq`

## Requirements
- R1: After reset the block is in the shipping state: `passEn`, `wakeDone` and `shipPending` are all 0.
- R2: In the shipping state, a valid adapter drives `passEn` and `wakeDone` to 1 with no button action.
- R3: With no adapter and `batHighAsync` at 1, a button press (`btnNAsync` at 0) sets `passEn` to 1 within three clocks, while `wakeDone` stays 0.
- R4: With `batHighAsync` at 0 and no adapter, a button press leaves `passEn` at 0.
- R5: Once the button has been held for `WAKE_TICKS` tick pulses, `wakeDone` goes to 1 and stays at 1 after the button is released.
- R6: A button released before `WAKE_TICKS` tick pulses, with no adapter present, returns the block to the shipping state (`passEn` 0).
- R7: A ship request while awake and with no adapter present returns the block to the shipping state.
- R8: A ship request while awake and with the adapter present sets `shipPending` and keeps `passEn` at 1. Removing the adapter then enters the shipping state and clears `shipPending`.
- R9: An adapter that arrives while the button has been held for at least `RESET_TICKS` ticks arms `shipPending`. If the button is released within `WAKE_TICKS` ticks of the adapter's arrival, the entry stays armed, and removing the adapter enters the shipping state.
- R10: An adapter that arrives after the button has been released arms nothing. Removing that adapter leaves the block awake.
- R11: A button that stays low for more than `WAKE_TICKS` ticks after the adapter's arrival cancels the armed entry (`shipPending` 0), and the block stays awake after the adapter is removed.
- R12: Hold time advances only on cycles where `tickEn` is 1. With `tickEn` held at 0, a held button never completes the wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | One-cycle timing pulse used to measure hold time |
| btnNAsync | input | 1 | Push button, active low, asynchronous |
| adapterOkAsync | input | 1 | Adapter-valid comparator, asynchronous |
| batHighAsync | input | 1 | Battery above highest undervoltage threshold, asynchronous |
| shipReq | input | 1 | One-cycle ship-mode request from the register file |
| passEn | output | 1 | Pass-path enable |
| wakeDone | output | 1 | Wake complete; host serial access allowed |
| shipPending | output | 1 | Ship entry deferred until the adapter is removed |

## Verification
The hardest case to reach is the button-armed deferred entry. It needs the button held past the reset duration, an adapter arriving during that hold, and the release landing inside the following wake-duration window. The stimulus drives the button low for about twice the reset duration with the tick running every cycle. It then raises the adapter and releases the button a few cycles later, which is well inside the window once the synchronizer delay is counted. A second run holds the button across the whole window to show the cancellation.

// File: rtl/shipWakePkg.sv
package shipWakePkg;

  typedef enum logic [1:0] {
    ST_SHIP   = 2'd0,
    ST_WAKING = 2'd1,
    ST_ACTIVE = 2'd2
  } wakeState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrHold;
    logic clrPost;
  } dpStrobe_t;

  // comparison results from datapath to control
  typedef struct packed {
    logic wakeReached;
    logic resetReached;
    logic postReached;
  } dpFlag_t;

endpackage

// File: rtl/syncBank.sv
module syncBank #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage[s] <= RST_VAL;
      end else if (s == 0) begin
        stage[s] <= dIn;
      end else begin
        stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign dOut = stage[STAGES-1];

endmodule

// File: rtl/satCounter.sv
module satCounter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc && (cnt != CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/holdTimer.sv
module holdTimer
  import shipWakePkg::*;
#(
  parameter int WAKE_TICKS  = 8,
  parameter int RESET_TICKS = 20
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      btnLow,
  input  dpStrobe_t strobe,
  output dpFlag_t   flags
);

  localparam int LIMIT = (WAKE_TICKS > RESET_TICKS) ? WAKE_TICKS : RESET_TICKS;
  localparam int CNT_W = $clog2(LIMIT + 2);
  localparam logic [CNT_W-1:0] WAKE_LIM  = CNT_W'(WAKE_TICKS);
  localparam logic [CNT_W-1:0] RESET_LIM = CNT_W'(RESET_TICKS);
  localparam int NUM_CNT = 2;

  logic [NUM_CNT-1:0] cntClr;
  logic [NUM_CNT-1:0] cntInc;
  logic [CNT_W-1:0]   cntVal [NUM_CNT];

  // counter 0: button hold time, counter 1: time since adapter arrival
  assign cntClr[0] = strobe.clrHold || !btnLow;
  assign cntInc[0] = btnLow && tickEn;
  assign cntClr[1] = strobe.clrPost;
  assign cntInc[1] = tickEn;

  for (genvar i = 0; i < NUM_CNT; i++) begin : gCnt
    satCounter #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rstN (rstN),
      .clr  (cntClr[i]),
      .inc  (cntInc[i]),
      .cnt  (cntVal[i])
    );
  end

  assign flags.wakeReached  = (cntVal[0] >= WAKE_LIM);
  assign flags.resetReached = (cntVal[0] >= RESET_LIM);
  assign flags.postReached  = (cntVal[1] >= WAKE_LIM);

endmodule

// File: rtl/wakeCtrl.sv
module wakeCtrl
  import shipWakePkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      btnLow,
  input  logic      adapterOk,
  input  logic      batHigh,
  input  logic      shipReq,
  input  dpFlag_t   flags,
  output dpStrobe_t strobe,
  output logic      passEn,
  output logic      wakeDone,
  output logic      shipPending
);

  wakeState_e state;
  logic adapterPrev;
  logic pendReq;
  logic pendBtn;
  logic postWatch;
  logic adapterRise;
  logic armBtn;

  assign adapterRise = adapterOk && !adapterPrev;
  assign armBtn = (state == ST_ACTIVE) && adapterRise && btnLow && flags.resetReached;

  always_comb begin
    strobe = '0;
    strobe.clrHold = (state == ST_SHIP);
    strobe.clrPost = armBtn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_SHIP;
      adapterPrev <= 1'b0;
      pendReq     <= 1'b0;
      pendBtn     <= 1'b0;
      postWatch   <= 1'b0;
    end else begin
      adapterPrev <= adapterOk;
      case (state)
        ST_SHIP: begin
          pendReq   <= 1'b0;
          pendBtn   <= 1'b0;
          postWatch <= 1'b0;
          if (adapterOk) begin
            state <= ST_ACTIVE;
          end else if (btnLow && batHigh) begin
            state <= ST_WAKING;
          end
        end
        ST_WAKING: begin
          if (adapterOk) begin
            state <= ST_ACTIVE;
          end else if (!btnLow) begin
            state <= ST_SHIP;
          end else if (flags.wakeReached) begin
            state <= ST_ACTIVE;
          end
        end
        ST_ACTIVE: begin
          if ((pendReq || pendBtn) && !adapterOk) begin
            state     <= ST_SHIP;
            pendReq   <= 1'b0;
            pendBtn   <= 1'b0;
            postWatch <= 1'b0;
          end else begin
            if (shipReq) begin
              if (adapterOk) begin
                pendReq <= 1'b1;
              end else begin
                state <= ST_SHIP;
              end
            end
            if (armBtn) begin
              pendBtn   <= 1'b1;
              postWatch <= 1'b1;
            end else if (postWatch) begin
              if (!btnLow) begin
                postWatch <= 1'b0;
              end else if (flags.postReached) begin
                pendBtn   <= 1'b0;
                postWatch <= 1'b0;
              end
            end
          end
        end
        default: state <= ST_SHIP;
      endcase
    end
  end

  assign passEn      = (state != ST_SHIP);
  assign wakeDone    = (state == ST_ACTIVE);
  assign shipPending = pendReq || pendBtn;

endmodule

// File: rtl/shipWakeSeq.sv
module shipWakeSeq
  import shipWakePkg::*;
#(
  parameter int WAKE_TICKS  = 8,
  parameter int RESET_TICKS = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic btnNAsync,
  input  logic adapterOkAsync,
  input  logic batHighAsync,
  input  logic shipReq,
  output logic passEn,
  output logic wakeDone,
  output logic shipPending
);

  logic [2:0] rawIn;
  logic [2:0] syncIn;
  logic btnLowS;
  logic adapterS;
  logic batHighS;
  dpStrobe_t strobe;
  dpFlag_t   flags;

  assign rawIn = {btnNAsync, adapterOkAsync, batHighAsync};

  syncBank #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (rawIn),
    .dOut (syncIn)
  );

  assign btnLowS  = !syncIn[2];
  assign adapterS = syncIn[1];
  assign batHighS = syncIn[0];

  holdTimer #(
    .WAKE_TICKS  (WAKE_TICKS),
    .RESET_TICKS (RESET_TICKS)
  ) u_timer (
    .clk    (clk),
    .rstN   (rstN),
    .tickEn (tickEn),
    .btnLow (btnLowS),
    .strobe (strobe),
    .flags  (flags)
  );

  wakeCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .btnLow      (btnLowS),
    .adapterOk   (adapterS),
    .batHigh     (batHighS),
    .shipReq     (shipReq),
    .flags       (flags),
    .strobe      (strobe),
    .passEn      (passEn),
    .wakeDone    (wakeDone),
    .shipPending (shipPending)
  );

endmodule

// File: rtl/shipWakeSeqChk.sv
module shipWakeSeqChk (
  input logic clk,
  input logic rstN,
  input logic btnLowS,
  input logic adapterS,
  input logic batHighS,
  input logic passEn,
  input logic wakeDone,
  input logic shipPending
);

  // R5
  done_needs_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeDone |-> passEn);

  // R3
  press_powers_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!passEn && btnLowS && batHighS && !adapterS) |=> passEn);

  // R4
  low_bat_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!passEn && !batHighS && !adapterS) |=> !passEn);

  // R6
  early_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (passEn && !wakeDone && !btnLowS && !adapterS) |=> !passEn);

  // R8
  pending_fires_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shipPending && !adapterS) |=> (!passEn && !shipPending));

  // R2
  adapter_wakes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!passEn && adapterS) |=> wakeDone);

endmodule

bind shipWakeSeq shipWakeSeqChk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .btnLowS     (btnLowS),
  .adapterS    (adapterS),
  .batHighS    (batHighS),
  .passEn      (passEn),
  .wakeDone    (wakeDone),
  .shipPending (shipPending)
);

// File: tb/shipWakeSeq_tb.sv
module shipWakeSeq_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b1;
  logic btnNAsync = 1'b1;
  logic adapterOkAsync = 1'b0;
  logic batHighAsync = 1'b1;
  logic shipReq = 1'b0;
  logic passEn, wakeDone, shipPending;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  shipWakeSeq u_dut (
    .clk            (clk),
    .rstN           (rstN),
    .tickEn         (tickEn),
    .btnNAsync      (btnNAsync),
    .adapterOkAsync (adapterOkAsync),
    .batHighAsync   (batHighAsync),
    .shipReq        (shipReq),
    .passEn         (passEn),
    .wakeDone       (wakeDone),
    .shipPending    (shipPending)
  );

  // vector: adapter, btnN, batHigh, tick, req, wait[7:0], expPass, expDone, expPend, reqTag[3:0]
  localparam int NVEC = 14;
  localparam logic [19:0] VEC [NVEC] = '{
    {5'b01110, 8'd4,  3'b000, 4'd1},  // R1 idle ship
    {5'b11110, 8'd6,  3'b110, 4'd2},  // R2 adapter wake
    {5'b01110, 8'd6,  3'b110, 4'd2},  // R2 stays awake after adapter leaves
    {5'b01111, 8'd6,  3'b000, 4'd7},  // R7 ship request, no adapter
    {5'b00010, 8'd10, 3'b000, 4'd4},  // R4 press with low battery
    {5'b01110, 8'd4,  3'b000, 4'd4},  // R4 release
    {5'b00110, 8'd5,  3'b100, 4'd3},  // R3 press powers pass path
    {5'b01110, 8'd8,  3'b000, 4'd6},  // R6 early release
    {5'b00100, 8'd30, 3'b100, 4'd12}, // R12 no ticks, no completion
    {5'b00110, 8'd20, 3'b110, 4'd5},  // R5 ticks resume, wake completes
    {5'b01110, 8'd5,  3'b110, 4'd5},  // R5 release keeps wake
    {5'b11110, 8'd5,  3'b110, 4'd8},  // R8 adapter on
    {5'b11111, 8'd5,  3'b111, 4'd8},  // R8 request deferred
    {5'b01110, 8'd6,  3'b000, 4'd8}   // R8 adapter removal ships
  };

  task automatic check3(input logic ep, input logic ed, input logic epd, input string tag);
    checks++;
    if (passEn !== ep || wakeDone !== ed || shipPending !== epd) begin
      errors++;
      $display("FAIL %s: got pass=%b done=%b pend=%b, expected pass=%b done=%b pend=%b",
               tag, passEn, wakeDone, shipPending, ep, ed, epd);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseReq();
    shipReq = 1'b1;
    @(negedge clk);
    shipReq = 1'b0;
  endtask

  initial begin
    waitCyc(3);
    // R1 during and just after reset
    check3(1'b0, 1'b0, 1'b0, "R1 in reset");
    rstN = 1'b1;
    waitCyc(2);
    check3(1'b0, 1'b0, 1'b0, "R1 after reset");

    for (int v = 0; v < NVEC; v++) begin
      adapterOkAsync = VEC[v][19];
      btnNAsync      = VEC[v][18];
      batHighAsync   = VEC[v][17];
      tickEn         = VEC[v][16];
      if (VEC[v][15]) pulseReq();
      waitCyc(int'(VEC[v][14:7]));
      check3(VEC[v][6], VEC[v][5], VEC[v][4], $sformatf("R%0d vector %0d", VEC[v][3:0], v));
    end

    // R9 armed by held button, released inside window
    btnNAsync = 1'b0; waitCyc(40);
    check3(1'b1, 1'b1, 1'b0, "R9 long hold awake");
    adapterOkAsync = 1'b1; waitCyc(4);
    check3(1'b1, 1'b1, 1'b1, "R9 armed on adapter");
    btnNAsync = 1'b1; waitCyc(12);
    check3(1'b1, 1'b1, 1'b1, "R9 stays armed after release");
    adapterOkAsync = 1'b0; waitCyc(6);
    check3(1'b0, 1'b0, 1'b0, "R9 adapter removal ships");

    // R11 held past window cancels
    btnNAsync = 1'b0; waitCyc(40);
    adapterOkAsync = 1'b1; waitCyc(20);
    check3(1'b1, 1'b1, 1'b0, "R11 cancelled");
    btnNAsync = 1'b1; waitCyc(4);
    adapterOkAsync = 1'b0; waitCyc(6);
    check3(1'b1, 1'b1, 1'b0, "R11 stays awake");
    pulseReq(); waitCyc(4);
    check3(1'b0, 1'b0, 1'b0, "R7 back to ship");

    // R10 released before adapter
    btnNAsync = 1'b0; waitCyc(40);
    btnNAsync = 1'b1; waitCyc(5);
    adapterOkAsync = 1'b1; waitCyc(5);
    check3(1'b1, 1'b1, 1'b0, "R10 nothing armed");
    adapterOkAsync = 1'b0; waitCyc(6);
    check3(1'b1, 1'b1, 1'b0, "R10 stays awake");

    // R1 reset mid-run
    rstN = 1'b0; waitCyc(2);
    rstN = 1'b1; waitCyc(3);
    check3(1'b0, 1'b0, 1'b0, "R1 reset from awake");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule